// File: doc/BRIEF.md
# Dual QSPI Flash Lane Router

This block sits between a quad-SPI byte engine and up to two external flash devices. The engine raises one select request and hands over bytes through a valid/ready handshake. The router turns each byte into SPI clock periods on the right set of four data lanes. It also drives the right device selects and returns the bytes it reads. A configuration word sets one of three wirings. In single mode one device sits on the lower bus. In stacked mode two devices share the lower clock and lanes, and only one device is selected at a time. In parallel mode each device has its own clock and lanes, and every byte is split bit by bit across the two.

Each SPI clock period takes two system clocks: one with the SPI clock low while data is presented, then one with it high. Read data is sampled at the edge that ends the high phase. A new configuration waits in a shadow register until the select request is low and no byte is in flight. A transfer therefore never changes wiring part way through.

Top module: `dqspi_lane_router`

## Requirements
- R1: After reset both selects are high (inactive), both SPI clocks are low, no lane is driven, tx_ready and rx_valid are low, and the routing is single mode.
- R2: Configuration bit 30 enables two devices, bit 29 selects separate buses and bit 28 selects the upper device. With bit 30 clear the mode is single whatever bit 29 holds. Bits 30 and 29 both set give parallel mode. Bit 30 set with bit 29 clear gives stacked mode.
- R3: A configuration write takes effect only on a cycle where sel_req is low and no byte is in flight. A write made while a transfer is open changes nothing until the transfer ends.
- R4: In single mode cs_n[0] goes low one cycle after sel_req rises and high one cycle after it falls. cs_n[1], sclk[1] and the upper lane enable stay inactive.
- R5: In stacked mode, upper-select clear drives only cs_n[0] and upper-select set drives only cs_n[1]. Both devices use sclk[0] and the lower lanes.
- R6: In parallel mode cs_n[0] and cs_n[1] fall and rise on the same cycle, and the upper-select bit has no effect. Both clocks run together.
- R7: In single and stacked modes a byte takes two SPI clock periods on the lower lanes, high nibble first. Each period is one clock with SPI clock low, then one with it high.
- R8: In parallel mode a byte takes one SPI clock period. Lower lanes 3..0 carry bits 6,4,2,0 and upper lanes 3..0 carry bits 7,5,3,1.
- R9: Read data is sampled at the edge ending each high phase. In parallel mode the two nibbles are merged back in the same bit order as R8, and in serial modes the first nibble is the high one. rx_valid pulses for one cycle right after the last sample.
- R10: tx_ready is high only when sel_req is high, a select is already low and no byte is in flight. A byte is taken on a cycle where tx_valid and tx_ready are both high.
- R11: Lane enables are high only while a write byte is in flight. The upper enable is high only in parallel mode, and the lanes read as zero when not enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| sel_req | input | 1 | Select request from the byte engine |
| tx_valid | input | 1 | Byte offered by the engine |
| tx_rd | input | 1 | 1 = read byte, 0 = write byte |
| tx_data | input | 8 | Byte to write |
| tx_ready | output | 1 | Router accepts a byte |
| rx_valid | output | 1 | One-cycle pulse with a read byte |
| rx_data | output | 8 | Read byte |
| cs_n | output | 2 | Active-low selects, bit 0 lower device, bit 1 upper |
| sclk | output | 2 | SPI clocks, bit 0 lower bus, bit 1 upper bus |
| io_lo_o | output | 4 | Lower lane output data |
| io_lo_oe | output | 1 | Lower lane output enable |
| io_lo_i | input | 4 | Lower lane input data |
| io_hi_o | output | 4 | Upper lane output data |
| io_hi_oe | output | 1 | Upper lane output enable |
| io_hi_i | input | 4 | Upper lane input data |

## Verification
Some properties are checked by assertions on every cycle. The active routing must stay frozen while a transfer is open. Stacked and single modes must never pull both selects low, and the upper select must stay high in single mode. The SPI clock high phase must last exactly one cycle. tx_ready may only appear with a select already low, and the upper clock only with both selects low. Other behaviour shows only in the directed scenarios: the bit order of the nibbles on each lane, the merging of read nibbles, which device a given upper-select value reaches, and the deferred switch from serial to parallel after a write made mid-transfer.

// File: rtl/dqr_pkg.sv
package dqr_pkg;

    localparam int CFG_W           = 32;
    localparam int CFG_TWO_MEM_BIT = 30;
    localparam int CFG_SEP_BUS_BIT = 29;
    localparam int CFG_UPPER_BIT   = 28;
    localparam int LANES           = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE   = 2'd0,
        MODE_STACKED  = 2'd1,
        MODE_PARALLEL = 2'd2
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  upper;
    } route_t;

    typedef struct packed {
        logic two_mem;
        logic sep_bus;
        logic upper;
    } cfg_bits_t;

    // Separate-bus without two-memory falls back to single; upper only matters when stacked.
    function automatic route_t decode_cfg(input cfg_bits_t c);
        route_t r;
        if (!c.two_mem)     r.mode = MODE_SINGLE;
        else if (c.sep_bus) r.mode = MODE_PARALLEL;
        else                r.mode = MODE_STACKED;
        r.upper = c.two_mem && !c.sep_bus && c.upper;
        return r;
    endfunction

endpackage

// File: rtl/dqr_cfg_reg.sv
module dqr_cfg_reg
    import dqr_pkg::*;
#(
    parameter int CFG_W    = dqr_pkg::CFG_W,
    parameter int TWO_BIT  = dqr_pkg::CFG_TWO_MEM_BIT,
    parameter int SEP_BIT  = dqr_pkg::CFG_SEP_BUS_BIT,
    parameter int UPPR_BIT = dqr_pkg::CFG_UPPER_BIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hold,
    output route_t           route
);

    cfg_bits_t shadow_q;
    cfg_bits_t active_q;
    logic      cfg_unused;

    assign cfg_unused = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (cfg_we) begin
                shadow_q.two_mem <= cfg_wdata[TWO_BIT];
                shadow_q.sep_bus <= cfg_wdata[SEP_BIT];
                shadow_q.upper   <= cfg_wdata[UPPR_BIT];
            end
            if (!hold) begin
                active_q <= shadow_q;
            end
        end
    end

    assign route = decode_cfg(active_q);

    // R3: routing frozen while a transfer is open
    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(route));

endmodule

// File: rtl/dqr_cs_gen.sv
module dqr_cs_gen
    import dqr_pkg::*;
#(
    parameter int NUM_DEV = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_req,
    input  route_t             route,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               cs_on
);

    logic [NUM_DEV-1:0] want;
    logic [NUM_DEV-1:0] cs_n_q;
    logic               cs_on_q;

    always_comb begin
        want    = '0;
        want[0] = !(route.mode == MODE_STACKED && route.upper);
        want[NUM_DEV-1] = (route.mode == MODE_PARALLEL) ||
                          (route.mode == MODE_STACKED && route.upper);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q  <= '1;
            cs_on_q <= 1'b0;
        end else begin
            cs_on_q <= sel_req;
            cs_n_q  <= sel_req ? ~want : '1;
        end
    end

    assign cs_n  = cs_n_q;
    assign cs_on = cs_on_q;

    // R5: outside parallel mode never both selects low
    assert_cs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        (route.mode != MODE_PARALLEL) |-> (cs_n_q != '0));

    // R6: in parallel mode both selects move together
    assert_cs_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (route.mode == MODE_PARALLEL) |-> (cs_n_q[0] == cs_n_q[NUM_DEV-1]));

    // R4: the upper select stays high in single mode
    assert_single_upper_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (route.mode == MODE_SINGLE) |-> cs_n_q[NUM_DEV-1]);

endmodule

// File: rtl/dqr_lane_shift.sv
module dqr_lane_shift
    import dqr_pkg::*;
#(
    parameter int LANES = dqr_pkg::LANES,
    localparam int BW   = 2 * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_req,
    input  logic             cs_on,
    input  mode_e            mode,
    input  logic             tx_valid,
    input  logic             tx_rd,
    input  logic [BW-1:0]    tx_data,
    output logic             tx_ready,
    output logic             busy,
    output logic             rx_valid,
    output logic [BW-1:0]    rx_data,
    output logic [1:0]       sclk,
    output logic [LANES-1:0] io_lo_o,
    output logic             io_lo_oe,
    input  logic [LANES-1:0] io_lo_i,
    output logic [LANES-1:0] io_hi_o,
    output logic             io_hi_oe,
    input  logic [LANES-1:0] io_hi_i
);

    logic          busy_q, ph_q, beat_q, rd_q, par_q, rx_valid_q;
    logic [BW-1:0] tx_q, rx_q, merged;
    logic [LANES-1:0] even_n, odd_n, lo_nib;

    // Bit interleave: lane i of the lower bus carries bit 2i, of the upper bus bit 2i+1
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign even_n[i]     = tx_q[2*i];
        assign odd_n[i]      = tx_q[2*i+1];
        assign merged[2*i]   = io_lo_i[i];
        assign merged[2*i+1] = io_hi_i[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q     <= 1'b0;
            ph_q       <= 1'b0;
            beat_q     <= 1'b0;
            rd_q       <= 1'b0;
            par_q      <= 1'b0;
            tx_q       <= '0;
            rx_q       <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (!busy_q) begin
                if (tx_valid && tx_ready) begin
                    busy_q <= 1'b1;
                    ph_q   <= 1'b0;
                    beat_q <= 1'b0;
                    rd_q   <= tx_rd;
                    par_q  <= (mode == MODE_PARALLEL);
                    tx_q   <= tx_data;
                end
            end else if (!ph_q) begin
                ph_q <= 1'b1;
            end else begin
                ph_q <= 1'b0;
                if (par_q) begin
                    rx_q       <= merged;
                    busy_q     <= 1'b0;
                    rx_valid_q <= rd_q;
                end else if (!beat_q) begin
                    rx_q[BW-1:LANES] <= io_lo_i;
                    beat_q           <= 1'b1;
                end else begin
                    rx_q[LANES-1:0] <= io_lo_i;
                    busy_q          <= 1'b0;
                    rx_valid_q      <= rd_q;
                end
            end
        end
    end

    always_comb begin
        if (par_q)       lo_nib = even_n;
        else if (beat_q) lo_nib = tx_q[LANES-1:0];
        else             lo_nib = tx_q[BW-1:LANES];
    end

    assign tx_ready = sel_req && cs_on && !busy_q;
    assign busy     = busy_q;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_q;
    assign sclk     = {busy_q && ph_q && par_q, busy_q && ph_q};
    assign io_lo_oe = busy_q && !rd_q;
    assign io_hi_oe = busy_q && !rd_q && par_q;
    assign io_lo_o  = io_lo_oe ? lo_nib : '0;
    assign io_hi_o  = io_hi_oe ? odd_n  : '0;

    // R7: the SPI clock high phase lasts one cycle
    assert_sclk_one_high_R7: assert property (@(posedge clk) disable iff (rst)
        sclk[0] |=> !sclk[0]);

    // R10: an accepted byte starts with SPI clock low
    assert_accept_start_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (busy && !sclk[0]));

    // R9: a read byte is returned right after a high phase
    assert_rx_after_high_R9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(sclk[0]));

endmodule

// File: rtl/dqspi_lane_router.sv
module dqspi_lane_router
    import dqr_pkg::*;
#(
    parameter int CFG_W = dqr_pkg::CFG_W,
    parameter int LANES = dqr_pkg::LANES,
    localparam int BW   = 2 * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             sel_req,
    input  logic             tx_valid,
    input  logic             tx_rd,
    input  logic [BW-1:0]    tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [BW-1:0]    rx_data,
    output logic [1:0]       cs_n,
    output logic [1:0]       sclk,
    output logic [LANES-1:0] io_lo_o,
    output logic             io_lo_oe,
    input  logic [LANES-1:0] io_lo_i,
    output logic [LANES-1:0] io_hi_o,
    output logic             io_hi_oe,
    input  logic [LANES-1:0] io_hi_i
);

    route_t route;
    logic   busy;
    logic   cs_on;

    dqr_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .hold      (sel_req || busy),
        .route     (route)
    );

    dqr_cs_gen #(.NUM_DEV(2)) u_cs (
        .clk     (clk),
        .rst     (rst),
        .sel_req (sel_req),
        .route   (route),
        .cs_n    (cs_n),
        .cs_on   (cs_on)
    );

    dqr_lane_shift #(.LANES(LANES)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sel_req  (sel_req),
        .cs_on    (cs_on),
        .mode     (route.mode),
        .tx_valid (tx_valid),
        .tx_rd    (tx_rd),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .busy     (busy),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .sclk     (sclk),
        .io_lo_o  (io_lo_o),
        .io_lo_oe (io_lo_oe),
        .io_lo_i  (io_lo_i),
        .io_hi_o  (io_hi_o),
        .io_hi_oe (io_hi_oe),
        .io_hi_i  (io_hi_i)
    );

    // R10: ready only appears with a select already low
    assert_ready_has_cs_R10: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> (cs_n != 2'b11));

    // R6: the upper clock runs only with both selects low
    assert_upper_clk_R6: assert property (@(posedge clk) disable iff (rst)
        sclk[1] |-> (cs_n == 2'b00));

endmodule

// File: tb/tb_dqspi_lane_router.sv
`timescale 1ns/1ps
module tb_dqspi_lane_router;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [31:0] cfg_wdata;
    logic       sel_req, tx_valid, tx_rd;
    logic [7:0] tx_data;
    logic       tx_ready, rx_valid;
    logic [7:0] rx_data;
    logic [1:0] cs_n, sclk;
    logic [3:0] io_lo_o, io_lo_i, io_hi_o, io_hi_i;
    logic       io_lo_oe, io_hi_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dqspi_lane_router dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .sel_req(sel_req), .tx_valid(tx_valid), .tx_rd(tx_rd), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .cs_n(cs_n), .sclk(sclk),
        .io_lo_o(io_lo_o), .io_lo_oe(io_lo_oe), .io_lo_i(io_lo_i),
        .io_hi_o(io_hi_o), .io_hi_oe(io_hi_oe), .io_hi_i(io_hi_i)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] evn(input logic [7:0] x);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = x[2*i];
        return r;
    endfunction

    function automatic logic [3:0] odd(input logic [7:0] x);
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = x[2*i+1];
        return r;
    endfunction

    task automatic write_cfg(input logic [31:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic open_cs(input logic [1:0] exp_cs, input string req);
        sel_req = 1'b1;
        chk("R10", "ready before select", {31'd0, tx_ready}, 32'd0);
        @(negedge clk);
        chk(req, "selects after request", {30'd0, cs_n}, {30'd0, exp_cs});
    endtask

    task automatic close_cs();
        sel_req = 1'b0;
        @(negedge clk);
        chk("R4", "selects released", {30'd0, cs_n}, 32'd3);
        @(negedge clk);
    endtask

    task automatic run_byte(input string req, input bit par, input bit rd,
                            input logic [7:0] wb, input logic [7:0] rb);
        logic [3:0] lo, hi;
        chk("R10", "ready with select open", {31'd0, tx_ready}, 32'd1);
        tx_valid = 1'b1; tx_rd = rd; tx_data = wb;
        @(negedge clk);
        tx_valid = 1'b0; tx_data = '0;
        for (int b = 0; b < (par ? 1 : 2); b++) begin
            if (rd) begin
                io_lo_i = par ? evn(rb) : (b == 0 ? rb[7:4] : rb[3:0]);
                io_hi_i = par ? odd(rb) : 4'h0;
            end
            lo = par ? evn(wb) : (b == 0 ? wb[7:4] : wb[3:0]);
            hi = par ? odd(wb) : 4'h0;
            chk("R7", "clocks low in first phase", {30'd0, sclk}, 32'd0);
            chk("R11", "lower enable", {31'd0, io_lo_oe}, {31'd0, !rd});
            chk("R11", "upper enable", {31'd0, io_hi_oe}, {31'd0, (!rd && par)});
            if (!rd) begin
                chk(req, "lower lanes", {28'd0, io_lo_o}, {28'd0, lo});
                chk(req, "upper lanes", {28'd0, io_hi_o}, {28'd0, hi});
            end
            @(negedge clk);
            chk(par ? "R6" : "R7", "clocks high phase", {30'd0, sclk}, {30'd0, par, 1'b1});
            @(negedge clk);
        end
        io_lo_i = '0; io_hi_i = '0;
        chk("R9", "rx_valid after last sample", {31'd0, rx_valid}, {31'd0, rd});
        if (rd) chk("R9", "read byte", {24'd0, rx_data}, {24'd0, rb});
        chk("R10", "ready again after byte", {31'd0, tx_ready}, 32'd1);
        @(negedge clk);
        chk("R9", "rx_valid is one pulse", {31'd0, rx_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "selects", {30'd0, cs_n}, 32'd3);
        chk("R1", "clocks", {30'd0, sclk}, 32'd0);
        chk("R1", "enables", {30'd0, io_lo_oe, io_hi_oe}, 32'd0);
        chk("R1", "ready/valid", {30'd0, tx_ready, rx_valid}, 32'd0);
        open_cs(2'b10, "R1");
        close_cs();
    endtask

    task automatic t_single();
        write_cfg(32'h0000_0000);
        @(negedge clk);
        open_cs(2'b10, "R4");
        run_byte("R7", 1'b0, 1'b0, 8'hA5, 8'h00);
        run_byte("R9", 1'b0, 1'b1, 8'h00, 8'h3C);
        chk("R4", "upper select idle", {31'd0, cs_n[1]}, 32'd1);
        close_cs();
    endtask

    task automatic t_sep_only();
        write_cfg(32'h2000_0000);
        @(negedge clk);
        open_cs(2'b10, "R2");
        run_byte("R2", 1'b0, 1'b0, 8'h1E, 8'h00);
        close_cs();
    endtask

    task automatic t_stacked();
        write_cfg(32'h4000_0000);
        @(negedge clk);
        open_cs(2'b10, "R5");
        run_byte("R5", 1'b0, 1'b0, 8'hC3, 8'h00);
        close_cs();
        write_cfg(32'h5000_0000);
        @(negedge clk);
        open_cs(2'b01, "R5");
        run_byte("R5", 1'b0, 1'b0, 8'h69, 8'h00);
        run_byte("R5", 1'b0, 1'b1, 8'h00, 8'hD2);
        close_cs();
    endtask

    task automatic t_parallel();
        write_cfg(32'h6000_0000);
        @(negedge clk);
        open_cs(2'b00, "R6");
        run_byte("R8", 1'b1, 1'b0, 8'hB4, 8'h00);
        run_byte("R8", 1'b1, 1'b0, 8'h55, 8'h00);
        run_byte("R9", 1'b1, 1'b1, 8'h00, 8'h96);
        close_cs();
        write_cfg(32'h7000_0000);
        @(negedge clk);
        open_cs(2'b00, "R6");
        run_byte("R8", 1'b1, 1'b0, 8'h2F, 8'h00);
        run_byte("R9", 1'b1, 1'b1, 8'h00, 8'hE1);
        close_cs();
    endtask

    task automatic t_cfg_hold();
        write_cfg(32'h0000_0000);
        @(negedge clk);
        open_cs(2'b10, "R4");
        write_cfg(32'h6000_0000);
        chk("R3", "selects unchanged by write", {30'd0, cs_n}, 32'd2);
        run_byte("R3", 1'b0, 1'b0, 8'h5A, 8'h00);
        chk("R3", "still single selects", {30'd0, cs_n}, 32'd2);
        close_cs();
        open_cs(2'b00, "R3");
        run_byte("R3", 1'b1, 1'b0, 8'h87, 8'h00);
        close_cs();
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; sel_req = 1'b0;
        tx_valid = 1'b0; tx_rd = 1'b0; tx_data = '0; io_lo_i = '0; io_hi_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_sep_only();
        t_stacked();
        t_parallel();
        t_cfg_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule